// File: doc/BRIEF.md
# Cable Reflectometry Test Sequencer

This block sequences a reflectometry test on a single-pair Ethernet link. Software programs silence codes, a transmit window in microseconds, a drive-level select and a tap window through a small register port. It then sets a start bit. The sequencer runs four phases in a fixed order. First comes an optional quiet period, then the modulated transmit window, then a second quiet period. Finally it parks the port in forced-link mode, where autonegotiation is not used. The analog transmitter and the correlation/peak search sit outside the block. The block drives `tx_enable`, `tx_level` and the tap window to them, and takes back a one-cycle peak strobe carrying detect, sign and location.

The peak result seen during the transmit window is latched and turned into a result code. A set sign means an open conductor. A clear sign means a short. No peak means a healthy cable. Activity from a live far end during either quiet period ends the test at once and reports a failure. Writes to a reset register abort a running test. The hardware variant of that reset also restores the configuration defaults.

A free-running microsecond prescaler, realigned at each phase entry, times the phases. Quiet periods are counted in microseconds as `ms * US_PER_MS`. The bench uses this to shrink the test.

Top module: `cable_refl_seq`

## Requirements
- R1: After reset, `phase` is 0 (idle), `test_done`, `test_fail` and `result` are 0. The duration register (address 3) reads 16000, the tap register (address 2) reads 0x2404, and the level/silence register (address 1) reads 0. `tap_end` is 36 and `tap_start` is 4.
- R2: After an accepted start, `phase` steps strictly 1 (pre-quiet), 2 (transmit), 3 (post-quiet), 4 (forced link), with `forced_link` high only in phase 4. Each timed phase lasts `N*CLK_PER_US+1` cycles, where N is its length in microseconds.
- R3: In register 1, bits [1:0] select the pre-quiet code and bits [3:2] select the post-quiet code. Codes 0, 1, 2 and 3 mean 0, 10, 100 and 1000 ms, so N = ms*US_PER_MS.
- R4: Register 3 holds the 16-bit transmit window in microseconds. `tx_enable` is high exactly in phase 2, for `dur*CLK_PER_US+1` cycles.
- R5: Bit 12 of register 1 is stored and driven on `tx_level` (0 low amplitude, 1 high).
- R6: In register 0, writing bit 15 starts a test. Bit 1 reads done and bit 0 reads fail. After a normal run, done rises on the same edge as the entry into phase 4 and never earlier.
- R7: A `peak_valid` strobe during phase 2 is latched into register 4 as bit 11 detect, bit 10 sign and bits [9:0] location. Strobes in any other phase leave register 4 unchanged.
- R8: On normal completion, `result` is 1 for detect with sign set (open), 2 for detect with sign clear (short) and 0 for no detect. It is 3 on a failed test.
- R9: Register 2 holds the end tap in bits [14:8] and the start tap in bits [6:0]. Both are driven on `tap_end` and `tap_start`.
- R10: Writing register 5 with bit 14 (soft) or bit 15 (hard) set returns the sequencer to idle and clears done and fail. The hard bit also restores the defaults of registers 1 to 3; the soft bit keeps them.
- R11: `link_act` high in phase 1 or 3 sends the sequencer to idle and sets both done and fail, with result 3. `link_act` in phase 2 has no effect.
- R12: A start written during phases 1 to 3 is ignored and does not restart the timers. A start from idle or phase 4 is accepted and clears done, fail, result and register 4.
- R13: `reg_rdata` returns the register selected by `reg_raddr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 16 | Registered read data |
| peak_valid | input | 1 | Peak-search result strobe |
| peak_det | input | 1 | Peak found |
| peak_sign | input | 1 | Peak polarity (1 = open) |
| peak_loc | input | 10 | Peak location |
| link_act | input | 1 | Far-end activity seen |
| tx_enable | output | 1 | Modulated transmit window active |
| tx_level | output | 1 | Transmit amplitude select |
| forced_link | output | 1 | Port handed over to forced-link mode |
| phase | output | 3 | Current phase (0 idle, 1 pre, 2 tx, 3 post, 4 forced) |
| tap_start | output | 7 | Start tap index to the detector |
| tap_end | output | 7 | End tap index to the detector |
| test_done | output | 1 | Test finished |
| test_fail | output | 1 | Test ended by far-end activity |
| result | output | 2 | Result code (0 ok, 1 open, 2 short, 3 fail) |

## Verification
The bound checker watches on every cycle that phases only advance along the legal order or drop to idle. It also checks that done and fail stay low while a test runs, that done first rises only on entry to forced link or together with fail, that fail implies done and result code 3, and that forced link implies done. Exact phase lengths for every pair of quiet codes and several windows cannot be seen by a cycle property; neither can the latched fault fields, the ignored strobes and restarts, or the restore of defaults on hard reset. The bench's sweeps and directed scenarios show those.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int LOC_W  = 10;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_PRE    = 3'd1,
    PH_TX     = 3'd2,
    PH_POST   = 3'd3,
    PH_FORCED = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_OPEN  = 2'd1,
    RES_SHORT = 2'd2,
    RES_FAIL  = 2'd3
  } result_t;

  typedef struct packed {
    logic             det;
    logic             sign;
    logic [LOC_W-1:0] loc;
  } fault_t;

  // register map
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG2  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DUR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_FAULT = 3'd4;
  localparam logic [ADDR_W-1:0] A_RST   = 3'd5;

  // bit positions
  localparam int B_START = 15;
  localparam int B_DONE  = 1;
  localparam int B_FAIL  = 0;
  localparam int B_LEVEL = 12;
  localparam int B_HWRST = 15;
  localparam int B_SWRST = 14;
  localparam int B_PKDET = 11;
  localparam int B_PKSGN = 10;
  localparam int F_POST  = 2;
  localparam int F_PRE   = 0;
  localparam int F_TEND  = 8;
  localparam int F_TSTRT = 0;
endpackage

// File: rtl/crs_cfg_regs.sv
module crs_cfg_regs
  import crs_pkg::*;
#(
  parameter int TAP_W     = 7,
  parameter int DUR_W     = 16,
  parameter int DUR_DEF   = 16000,
  parameter int TEND_DEF  = 36,
  parameter int TSTRT_DEF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              level_q,
  output logic [1:0]        pre_code_q,
  output logic [1:0]        post_code_q,
  output logic [TAP_W-1:0]  tap_start_q,
  output logic [TAP_W-1:0]  tap_end_q,
  output logic [DUR_W-1:0]  dur_q,
  output logic              start_req,
  output logic              abort_req
);
  logic rst_wr, hard_wr;

  assign rst_wr    = wr_en && (wr_addr == A_RST);
  assign hard_wr   = rst_wr && wr_data[B_HWRST];
  assign abort_req = rst_wr && (wr_data[B_HWRST] || wr_data[B_SWRST]);
  assign start_req = wr_en && (wr_addr == A_CTRL) && wr_data[B_START];

  always_ff @(posedge clk) begin
    if (rst || hard_wr) begin
      level_q     <= 1'b0;
      pre_code_q  <= 2'd0;
      post_code_q <= 2'd0;
      tap_start_q <= TAP_W'(TSTRT_DEF);
      tap_end_q   <= TAP_W'(TEND_DEF);
      dur_q       <= DUR_W'(DUR_DEF);
    end else if (wr_en) begin
      case (wr_addr)
        A_CFG1: begin
          level_q     <= wr_data[B_LEVEL];
          post_code_q <= wr_data[F_POST +: 2];
          pre_code_q  <= wr_data[F_PRE +: 2];
        end
        A_CFG2: begin
          tap_end_q   <= wr_data[F_TEND +: TAP_W];
          tap_start_q <= wr_data[F_TSTRT +: TAP_W];
        end
        A_DUR:   dur_q <= wr_data[DUR_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crs_timebase.sv
module crs_timebase #(
  parameter int CLK_PER_US = 125,
  parameter int CNT_W      = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  localparam int PS_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [PS_W-1:0]  ps_q;
  logic [CNT_W-1:0] cnt_q;
  logic             us_tick;

  assign us_tick = (ps_q == PS_W'(CLK_PER_US - 1));
  assign expired = (cnt_q == '0);

  // prescaler runs freely, realigned whenever a phase loads its length
  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      ps_q  <= '0;
      cnt_q <= load_val;
    end else begin
      ps_q <= us_tick ? '0 : ps_q + 1'b1;
      if (us_tick && !expired) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/crs_fsm.sv
module crs_fsm
  import crs_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000,
  parameter int DUR_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             abort_req,
  input  logic [1:0]       pre_code,
  input  logic [1:0]       post_code,
  input  logic [DUR_W-1:0] dur,
  input  logic             peak_valid,
  input  logic             peak_det,
  input  logic             peak_sign,
  input  logic [LOC_W-1:0] peak_loc,
  input  logic             link_act,
  output phase_t           phase_q,
  output logic             done_q,
  output logic             fail_q,
  output result_t          result_q,
  output fault_t           fault_q
);
  localparam int SIL_MAX = 1000 * US_PER_MS;
  localparam int DUR_MAX = (1 << DUR_W) - 1;
  localparam int TMR_MAX = (SIL_MAX > DUR_MAX) ? SIL_MAX : DUR_MAX;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  function automatic logic [TMR_W-1:0] sil_us(input logic [1:0] code);
    case (code)
      2'd0:    return '0;
      2'd1:    return TMR_W'(10 * US_PER_MS);
      2'd2:    return TMR_W'(100 * US_PER_MS);
      default: return TMR_W'(1000 * US_PER_MS);
    endcase
  endfunction

  phase_t           ph_d;
  logic             load, expired, accept, fin_ok, fin_fail;
  logic [TMR_W-1:0] load_val;
  result_t          res_ok;

  crs_timebase #(.CLK_PER_US(CLK_PER_US), .CNT_W(TMR_W)) u_tb (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(load_val),
    .expired (expired)
  );

  always_comb begin
    ph_d     = phase_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    fin_ok   = 1'b0;
    fin_fail = 1'b0;
    if (abort_req) begin
      ph_d = PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE, PH_FORCED: if (start_req) begin
          ph_d     = PH_PRE;
          load     = 1'b1;
          load_val = sil_us(pre_code);
          accept   = 1'b1;
        end
        PH_PRE: if (link_act) begin
          ph_d     = PH_IDLE;
          fin_fail = 1'b1;
        end else if (expired) begin
          ph_d     = PH_TX;
          load     = 1'b1;
          load_val = TMR_W'(dur);
        end
        PH_TX: if (expired) begin
          ph_d     = PH_POST;
          load     = 1'b1;
          load_val = sil_us(post_code);
        end
        PH_POST: if (link_act) begin
          ph_d     = PH_IDLE;
          fin_fail = 1'b1;
        end else if (expired) begin
          ph_d   = PH_FORCED;
          fin_ok = 1'b1;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!fault_q.det)      res_ok = RES_OK;
    else if (fault_q.sign) res_ok = RES_OPEN;
    else                   res_ok = RES_SHORT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      result_q <= RES_OK;
      fault_q  <= '0;
    end else begin
      phase_q <= ph_d;
      if (abort_req) begin
        done_q   <= 1'b0;
        fail_q   <= 1'b0;
        result_q <= RES_OK;
      end else if (accept) begin
        done_q   <= 1'b0;
        fail_q   <= 1'b0;
        result_q <= RES_OK;
        fault_q  <= '0;
      end else if (fin_fail) begin
        done_q   <= 1'b1;
        fail_q   <= 1'b1;
        result_q <= RES_FAIL;
      end else if (fin_ok) begin
        done_q   <= 1'b1;
        result_q <= res_ok;
      end else if (phase_q == PH_TX && peak_valid) begin
        fault_q <= '{det: peak_det, sign: peak_sign, loc: peak_loc};
      end
    end
  end
endmodule

// File: rtl/cable_refl_seq.sv
module cable_refl_seq
  import crs_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000,
  parameter int DUR_DEF    = 16000,
  parameter int TEND_DEF   = 36,
  parameter int TSTRT_DEF  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  input  logic [2:0]  reg_raddr,
  output logic [15:0] reg_rdata,
  input  logic        peak_valid,
  input  logic        peak_det,
  input  logic        peak_sign,
  input  logic [9:0]  peak_loc,
  input  logic        link_act,
  output logic        tx_enable,
  output logic        tx_level,
  output logic        forced_link,
  output logic [2:0]  phase,
  output logic [6:0]  tap_start,
  output logic [6:0]  tap_end,
  output logic        test_done,
  output logic        test_fail,
  output logic [1:0]  result
);
  localparam int TAP_W = 7;
  localparam int DUR_W = 16;

  logic             level_q, start_req, abort_req;
  logic [1:0]       pre_code, post_code;
  logic [DUR_W-1:0] dur_q;
  phase_t           phase_q;
  result_t          result_q;
  fault_t           fault_q;
  logic             done_q, fail_q;

  crs_cfg_regs #(
    .TAP_W(TAP_W), .DUR_W(DUR_W), .DUR_DEF(DUR_DEF),
    .TEND_DEF(TEND_DEF), .TSTRT_DEF(TSTRT_DEF)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr),
    .wr_addr    (reg_addr),
    .wr_data    (reg_wdata),
    .level_q    (level_q),
    .pre_code_q (pre_code),
    .post_code_q(post_code),
    .tap_start_q(tap_start),
    .tap_end_q  (tap_end),
    .dur_q      (dur_q),
    .start_req  (start_req),
    .abort_req  (abort_req)
  );

  crs_fsm #(
    .CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS), .DUR_W(DUR_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .abort_req (abort_req),
    .pre_code  (pre_code),
    .post_code (post_code),
    .dur       (dur_q),
    .peak_valid(peak_valid),
    .peak_det  (peak_det),
    .peak_sign (peak_sign),
    .peak_loc  (peak_loc),
    .link_act  (link_act),
    .phase_q   (phase_q),
    .done_q    (done_q),
    .fail_q    (fail_q),
    .result_q  (result_q),
    .fault_q   (fault_q)
  );

  assign tx_enable   = (phase_q == PH_TX);
  assign forced_link = (phase_q == PH_FORCED);
  assign tx_level    = level_q;
  assign phase       = phase_q;
  assign test_done   = done_q;
  assign test_fail   = fail_q;
  assign result      = result_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_raddr)
        A_CTRL: begin
          reg_rdata[B_DONE] <= done_q;
          reg_rdata[B_FAIL] <= fail_q;
        end
        A_CFG1: begin
          reg_rdata[B_LEVEL]      <= level_q;
          reg_rdata[F_POST +: 2]  <= post_code;
          reg_rdata[F_PRE +: 2]   <= pre_code;
        end
        A_CFG2: begin
          reg_rdata[F_TEND +: TAP_W]  <= tap_end;
          reg_rdata[F_TSTRT +: TAP_W] <= tap_start;
        end
        A_DUR: reg_rdata <= dur_q;
        A_FAULT: begin
          reg_rdata[B_PKDET]     <= fault_q.det;
          reg_rdata[B_PKSGN]     <= fault_q.sign;
          reg_rdata[LOC_W-1:0]   <= fault_q.loc;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cable_refl_seq_chk.sv
module cable_refl_seq_chk
  import crs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] phase,
  input logic       test_done,
  input logic       test_fail,
  input logic [1:0] result,
  input logic       forced_link
);
  // R2: legal phase successors
  a_r2_idle_exit: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_IDLE && phase != PH_IDLE) |-> phase == PH_PRE);
  a_r2_pre_exit: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_PRE && phase != PH_PRE) |-> (phase == PH_TX || phase == PH_IDLE));
  a_r2_tx_exit: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_TX && phase != PH_TX) |-> (phase == PH_POST || phase == PH_IDLE));
  a_r2_post_exit: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_POST && phase != PH_POST) |-> (phase == PH_FORCED || phase == PH_IDLE));
  a_r2_forced_done: assert property (@(posedge clk) disable iff (rst)
    forced_link |-> test_done);
  // R6: done first appears at the end of the run or with a fail
  a_r6_done_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(test_done) |-> ((phase == PH_FORCED && !test_fail) || (phase == PH_IDLE && test_fail)));
  // R12: nothing reported while a test is in flight
  a_r12_quiet_running: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PRE || phase == PH_TX || phase == PH_POST) |-> (!test_done && !test_fail));
  // R11: a fail is always a finished test
  a_r11_fail_done: assert property (@(posedge clk) disable iff (rst)
    test_fail |-> test_done);
  // R8: fail code
  a_r8_fail_code: assert property (@(posedge clk) disable iff (rst)
    test_fail |-> result == RES_FAIL);
endmodule

bind cable_refl_seq cable_refl_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .phase      (phase),
  .test_done  (test_done),
  .test_fail  (test_fail),
  .result     (result),
  .forced_link(forced_link)
);

// File: tb/cable_refl_seq_tb.sv
module cable_refl_seq_tb;
  localparam int P = 2;   // clocks per microsecond
  localparam int M = 2;   // microseconds per millisecond (scaled)

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [15:0] reg_rdata;
  logic        peak_valid = 1'b0, peak_det = 1'b0, peak_sign = 1'b0;
  logic [9:0]  peak_loc = '0;
  logic        link_act = 1'b0;
  logic        tx_enable, tx_level, forced_link, test_done, test_fail;
  logic [2:0]  phase;
  logic [6:0]  tap_start, tap_end;
  logic [1:0]  result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  cable_refl_seq #(.CLK_PER_US(P), .US_PER_MS(M)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .peak_valid(peak_valid), .peak_det(peak_det), .peak_sign(peak_sign),
    .peak_loc(peak_loc), .link_act(link_act), .tx_enable(tx_enable),
    .tx_level(tx_level), .forced_link(forced_link), .phase(phase),
    .tap_start(tap_start), .tap_end(tap_end), .test_done(test_done),
    .test_fail(test_fail), .result(result)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // R13: data valid one cycle after the address
  task automatic rd(input logic [2:0] a, output int d);
    reg_raddr = a;
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  function automatic int ms_of(input int code);
    return (code == 0) ? 0 : (code == 1) ? 10 : (code == 2) ? 100 : 1000;
  endfunction

  // pk: 0 none, 1 open, 2 short; pk_ph: phase in which the strobe is given
  task automatic run_seq(input int pre, input int post, input int dur, input int lvl,
                         input int pk, input int pk_ph, input int lk_tx, input int loc);
    int n_pre, n_tx, n_post, prev, bad_order, early, txmis, guard, d, exp_res, exp_flt;
    wr(3'd1, 16'((lvl << 12) | (post << 2) | pre));
    wr(3'd3, 16'(dur));
    chk("R5 tx_level", int'(tx_level), lvl);
    wr(3'd0, 16'h8000);
    n_pre = 0; n_tx = 0; n_post = 0; prev = 1; bad_order = 0; early = 0; txmis = 0; guard = 0;
    while (phase != 3'd4 && phase != 3'd0 && guard < 20000) begin
      peak_valid = 1'b0; link_act = 1'b0;
      if (int'(phase) < prev) bad_order = 1;
      prev = int'(phase);
      if (test_done || test_fail) early = 1;
      if (tx_enable != (phase == 3'd2)) txmis = txmis + 1;
      if (phase == 3'd1) n_pre = n_pre + 1;
      if (phase == 3'd2) n_tx = n_tx + 1;
      if (phase == 3'd3) n_post = n_post + 1;
      if (pk != 0 && int'(phase) == pk_ph &&
          ((pk_ph == 1 && n_pre == 1) || (pk_ph == 2 && n_tx == 1))) begin
        peak_valid = 1'b1; peak_det = 1'b1; peak_sign = (pk == 1);
        peak_loc = 10'(loc);
      end
      if (lk_tx != 0 && phase == 3'd2 && n_tx == 1) link_act = 1'b1;
      guard = guard + 1;
      @(negedge clk);
    end
    peak_valid = 1'b0; link_act = 1'b0;
    chk("R2 final phase forced", int'(phase), 4);
    chk("R2 forced_link", int'(forced_link), 1);
    chk("R2 phase order", bad_order, 0);
    chk("R3 pre length", n_pre, ms_of(pre) * M * P + 1);
    chk("R3 post length", n_post, ms_of(post) * M * P + 1);
    chk("R4 tx length", n_tx, dur * P + 1);
    chk("R4 tx_enable only in tx", txmis, 0);
    chk("R6 no early done", early, 0);
    chk("R6 done", int'(test_done), 1);
    chk("R11 no fail", int'(test_fail), 0);
    exp_res = (pk_ph == 2) ? pk : 0;
    exp_flt = (pk_ph != 2 || pk == 0) ? 0 :
              ((1 << 11) | ((pk == 1) ? (1 << 10) : 0) | loc);
    chk("R8 result", int'(result), exp_res);
    rd(3'd4, d); chk("R7 fault register", d, exp_flt);
    rd(3'd0, d); chk("R6 ctrl readback", d, 2);
  endtask

  initial begin
    int d, rem, idx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 phase", int'(phase), 0);
    chk("R1 done", int'(test_done), 0);
    chk("R1 fail", int'(test_fail), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 tap_end", int'(tap_end), 36);
    chk("R1 tap_start", int'(tap_start), 4);
    rd(3'd3, d); chk("R1 duration default", d, 16000);
    rd(3'd2, d); chk("R1 tap register default", d, 16'h2404);
    rd(3'd1, d); chk("R1 cfg1 default", d, 0);
    rd(3'd0, d); chk("R1 R13 ctrl", d, 0);

    // R2 R3 R4 R8: sweep of every silence code pair
    idx = 0;
    for (int pr = 0; pr < 4; pr++) begin
      for (int po = 0; po < 4; po++) begin
        run_seq(pr, po, 3, idx % 2, idx % 3, 2, 0, idx * 37 + 5);
        idx = idx + 1;
      end
    end
    // R4 window extremes, R11 link in tx ignored, R7 strobe outside tx ignored
    run_seq(0, 0, 0, 0, 1, 2, 0, 1023);
    run_seq(0, 0, 40, 1, 2, 2, 1, 512);
    run_seq(1, 0, 2, 0, 1, 1, 0, 77);

    // R9 tap forwarding
    wr(3'd2, 16'h3209);
    chk("R9 tap_end", int'(tap_end), 16'h32);
    chk("R9 tap_start", int'(tap_start), 9);
    rd(3'd2, d); chk("R9 tap readback", d, 16'h3209);

    // R12 start while running ignored
    wr(3'd1, 16'h0001); wr(3'd3, 16'd2);
    wr(3'd0, 16'h8000);
    repeat (20) @(negedge clk);
    wr(3'd0, 16'h8000);
    rem = 0;
    while (phase == 3'd1 && rem < 1000) begin rem = rem + 1; @(negedge clk); end
    chk("R12 pre not restarted", rem, 10 * M * P + 1 - 21);
    while (phase != 3'd4 && rem < 5000) begin rem = rem + 1; @(negedge clk); end
    chk("R12 run completes", int'(test_done), 1);
    // R12 start from forced accepted, clears done
    wr(3'd0, 16'h8000);
    chk("R12 restart from forced", int'(phase), 1);
    chk("R12 done cleared", int'(test_done), 0);

    // R10 soft abort during tx keeps config
    wr(3'd3, 16'd40);
    while (phase != 3'd2) @(negedge clk);
    wr(3'd5, 16'h4000);
    chk("R10 soft abort idle", int'(phase), 0);
    chk("R10 soft abort done", int'(test_done), 0);
    rd(3'd3, d); chk("R10 soft keeps duration", d, 40);
    // R10 abort from forced clears done
    wr(3'd1, 16'h0000); wr(3'd3, 16'd0);
    wr(3'd0, 16'h8000);
    while (phase != 3'd4) @(negedge clk);
    wr(3'd5, 16'h4000);
    chk("R10 abort forced idle", int'(phase), 0);
    chk("R10 abort clears done", int'(test_done), 0);
    // R10 hard abort restores defaults
    wr(3'd1, 16'h100F); wr(3'd0, 16'h8000);
    wr(3'd5, 16'h8000);
    chk("R10 hard abort idle", int'(phase), 0);
    rd(3'd3, d); chk("R10 hard duration default", d, 16000);
    rd(3'd2, d); chk("R10 hard tap default", d, 16'h2404);
    rd(3'd1, d); chk("R10 hard cfg1 default", d, 0);
    chk("R10 hard tx_level", int'(tx_level), 0);

    // R11 link activity in pre
    wr(3'd1, 16'h0001); wr(3'd3, 16'd1);
    wr(3'd0, 16'h8000);
    repeat (5) @(negedge clk);
    link_act = 1'b1; @(negedge clk); link_act = 1'b0;
    chk("R11 pre link idle", int'(phase), 0);
    chk("R11 pre link done", int'(test_done), 1);
    chk("R11 pre link fail", int'(test_fail), 1);
    chk("R8 fail code", int'(result), 3);
    rd(3'd0, d); chk("R11 ctrl readback", d, 3);
    // R11 link activity in post
    wr(3'd1, 16'h0004); wr(3'd3, 16'd0);
    wr(3'd0, 16'h8000);
    chk("R12 start clears fail", int'(test_fail), 0);
    while (phase != 3'd3) @(negedge clk);
    link_act = 1'b1; @(negedge clk); link_act = 1'b0;
    chk("R11 post link idle", int'(phase), 0);
    chk("R11 post link fail", int'(test_fail), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule